// File: doc/BRIEF.md
# PWM Timebase Prescaler with Accelerated Test Mode

This block is the timebase for a slow PWM regulation loop. An 8-bit counter advances on every clock of the internal oscillator and runs freely, so it wraps every 256 clocks. Downstream logic receives three things from it:

- the whole count;
- a 4-bit phase value that steps a 16-level duty-cycle waveform;
- a one-clock period strobe that marks the end of each PWM period.

A test select input speeds everything up by a factor of 16. When it is held high, the timebase comes from the low four counter bits instead of the whole counter. The phase then repeats every 16 clocks, and the period strobe fires every 16 clocks. Every timer that depends on the PWM rate therefore runs 16 times faster.

The test select is passed through a two-flop synchronizer before it is used. That synchronizer resets to normal mode, which matches a test pin that is pulled low when nothing drives it. A separate nibble output always carries the fast phase (the low four count bits), whatever the mode.

Top module: `pwm_timebase`

## Requirements
- R1: While `rst` is high at a clock edge, the count is cleared to 0 and the synchronized mode is cleared to normal. After that edge, `count_o` is 0, `phase_o` is 0 and `period_stb_o` is 0.
- R2: On each clock edge with `rst` low, `count_o` increases by exactly 1. After 255 it wraps to 0.
- R3: In normal mode, `phase_o` equals `count_o[7:4]`.
- R4: In normal mode, `period_stb_o` is high exactly when `count_o` is 255. This gives one single-clock pulse every 256 clocks.
- R5: In test mode, `phase_o` equals `count_o[3:0]`.
- R6: In test mode, `period_stb_o` is high exactly when `count_o[3:0]` is 15. This gives one single-clock pulse every 16 clocks.
- R7: A value of `test_mode_i` sampled at clock edge k sets the mode used by the outputs from edge k+2 onward. That is, the input passes through two flops.
- R8: `fast_phase_o` equals `count_o[3:0]` in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| test_mode_i | input | 1 | Asynchronous accelerated-test select (1 = test mode) |
| count_o | output | 8 | Free-running counter value |
| phase_o | output | 4 | 16-step waveform phase for the selected timebase |
| period_stb_o | output | 1 | One-clock pulse on the last clock of each PWM period |
| fast_phase_o | output | 4 | Low counter nibble (phase of the accelerated timebase) |

## Verification
The assertions take for granted that `rst` is held high across at least one clock edge before any other checking starts. This ensures the counter and the synchronizer hold known values.

They also take for granted that the test select may change on any cycle. The stimulus makes use of this: it holds the select for random lengths of 1 to 600 cycles, and it includes single-cycle glitches. Every change is driven half a clock away from the sampling edge.

Reset pulses are applied at random points in mid-count, so that both modes are observed across their strobe and wrap boundaries.

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 8,
  parameter int PH_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             test_mode_i,
  output logic [CNT_W-1:0] count_o,
  output logic [PH_W-1:0]  phase_o,
  output logic             period_stb_o,
  output logic [PH_W-1:0]  fast_phase_o
);

  localparam int SYNC_N = 2;

  logic [CNT_W-1:0]  cnt_q;
  logic [SYNC_N-1:0] sync_q;
  logic              fast_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sync_q <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      sync_q <= {sync_q[SYNC_N-2:0], test_mode_i};
    end
  end

  assign fast_mode    = sync_q[SYNC_N-1];
  assign count_o      = cnt_q;
  assign fast_phase_o = cnt_q[PH_W-1:0];
  assign phase_o      = fast_mode ? cnt_q[PH_W-1:0] : cnt_q[CNT_W-1 -: PH_W];
  assign period_stb_o = fast_mode ? (&cnt_q[PH_W-1:0]) : (&cnt_q);

  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> (count_o == '0 && !fast_mode)); // R1
  AST_CNT_STEP:  assert property (@(posedge clk) disable iff (rst)
                   1'b1 |=> count_o == $past(count_o) + 1'b1); // R2
  AST_NORM_WRAP: assert property (@(posedge clk) disable iff (rst)
                   (period_stb_o && !fast_mode) |=> count_o == '0); // R4
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
                   period_stb_o |=> !period_stb_o); // R4
  AST_TEST_WRAP: assert property (@(posedge clk) disable iff (rst)
                   (period_stb_o && fast_mode) |=> fast_phase_o == '0); // R6
  AST_MODE_LAG:  assert property (@(posedge clk) disable iff (rst)
                   $rose(fast_mode) |-> $past(test_mode_i, 2)); // R7
  AST_FAST_NIB:  assert property (@(posedge clk) disable iff (rst)
                   1'b1 |=> fast_phase_o == $past(fast_phase_o) + 1'b1); // R8

endmodule

// File: tb/tb_pwm_timebase.sv
`timescale 1ns/1ps
module tb_pwm_timebase;
  logic clk = 0, rst = 1, test_mode_i = 0;
  logic [7:0] count_o;
  logic [3:0] phase_o, fast_phase_o;
  logic period_stb_o;
  int checks = 0, fails = 0;
  bit done = 0;

  pwm_timebase dut (.clk(clk), .rst(rst), .test_mode_i(test_mode_i), .count_o(count_o),
                    .phase_o(phase_o), .period_stb_o(period_stb_o), .fast_phase_o(fast_phase_o));

  always #2.5 clk = ~clk;

  logic [7:0] m_cnt = 0;
  logic m_s1 = 0, m_s2 = 0;
  always @(posedge clk) begin
    if (rst) begin m_cnt <= 0; m_s1 <= 0; m_s2 <= 0; end
    else begin m_cnt <= m_cnt + 8'd1; m_s1 <= test_mode_i; m_s2 <= m_s1; end
  end

  function automatic logic [3:0] exp_phase(logic [7:0] c, logic m);
    return m ? c[3:0] : c[7:4];
  endfunction
  function automatic logic exp_stb(logic [7:0] c, logic m);
    return m ? (c[3:0] == 4'hF) : (c == 8'hFF);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 count", count_o, m_cnt);
    chk(m_s2 ? "R5 phase" : "R3 phase", phase_o, exp_phase(m_cnt, m_s2));
    chk(m_s2 ? "R6 strobe" : "R4 strobe", period_stb_o, exp_stb(m_cnt, m_s2));
    chk("R8 fast nibble", fast_phase_o, m_cnt[3:0]);
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5EED_1234;
    int n_stb;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R1 count", count_o, 0);
    chk("R1 phase", phase_o, 0);
    chk("R1 strobe", period_stb_o, 0);
    rst = 0;
    n_stb = 0;
    for (int i = 0; i < 600; i++) begin step(); if (period_stb_o) n_stb++; end
    chk("R4 strobes in 600 normal clocks", n_stb, 2);
    rst = 1; @(negedge clk); rst = 0;
    repeat (20) step();
    test_mode_i = 1;
    step();
    chk("R7 one edge later still normal phase", phase_o, count_o[7:4]);
    step();
    chk("R7 two edges later test phase", phase_o, count_o[3:0]);
    n_stb = 0;
    for (int i = 0; i < 160; i++) begin step(); if (period_stb_o) n_stb++; end
    chk("R6 strobes in 160 test clocks", n_stb, 10);
    test_mode_i = 0;
    for (int r = 0; r < 120; r++) begin
      int hold = 1 + ($urandom % 600);
      if (($urandom % 8) == 0) begin
        rst = 1; @(negedge clk);
        chk("R1 count after reset", count_o, 0);
        chk("R1 strobe after reset", period_stb_o, 0);
        rst = 0;
      end
      test_mode_i = $urandom % 2;
      if (($urandom % 4) == 0) hold = 1;
      for (int k = 0; k < hold; k++) step();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule